// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It advances only on cycles where a divided-down conversion-clock enable (`tad_tick`) is high, so one enabled cycle is one conversion period. Software sets a start bit. The sequencer can then spend a selectable number of periods acquiring the input. Next it opens the hold switch and resolves the code one bit per period, most significant bit first. It does this by driving a trial code to an external DAC and reading back a comparator decision.

When a conversion finishes, the code is latched into a result register, a sticky done flag is raised and the start bit drops. Continuous mode is the exception: there the start bit stays set and the next conversion follows by itself. Software can abort a conversion by clearing the start bit. The bits resolved up to that point are then kept in the result register and the flag is left alone. A finished or aborted conversion is always followed by a fixed two-period recovery. A start request made during the recovery waits until it ends.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, done_flag, result and dac_code are all 0, and sample_on is 1.
- R2: The acq_sel codes 0 to 7 select 0, 2, 4, 6, 8, 12, 16 and 20 acquisition periods. From idle, sample_on falls at the enabled tick number acq+1 after the start bit is set.
- R3: While a conversion runs, sample_on is 0 for exactly 11 enabled ticks.
- R4: On entry to conversion, dac_code is 10'h200. Each later tick resolves the current trial bit, keeping it when cmp_below is 0 and clearing it when cmp_below is 1, and sets the next lower bit as the new trial. Bits below the trial bit are 0.
- R5: On the 11th conversion tick, the result takes the resolved code, done_flag is set and busy is cleared (continuous mode off).
- R6: done_flag stays set until a flag_clr pulse. A completion in the same cycle as flag_clr wins.
- R7: A start_clr pulse during a conversion aborts it at once. The result takes only the bits already resolved, with the pending trial bit excluded. done_flag keeps its value, busy is 0 and sample_on returns to 1.
- R8: After a completion or an abort, two enabled ticks pass before a new conversion can begin. A start request made during that time is held, and with acq_sel 0 the conversion begins on the second tick.
- R9: With cont_en set, completion loads the result and the flag but keeps busy at 1. The next conversion then begins automatically after the recovery.
- R10: A start_clr pulse during acquisition returns the block to tracking, leaves the result unchanged, and starts nothing on later ticks.
- R11: dac_code is 0 whenever no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tad_tick | input | 1 | One-cycle enable marking each conversion period |
| start_set | input | 1 | Pulse that sets the start/busy bit |
| start_clr | input | 1 | Pulse that clears the start/busy bit (abort) |
| acq_sel | input | 3 | Acquisition length select |
| cont_en | input | 1 | Continuous conversion enable |
| flag_clr | input | 1 | Pulse that clears the done flag |
| cmp_below | input | 1 | Comparator: input is below the DAC level |
| busy | output | 1 | Start/busy bit |
| sample_on | output | 1 | Hold switch connected to the input |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Result register |
| done_flag | output | 1 | Sticky conversion-done flag |

## Verification
The hardest case to reach is a start request that arrives during the recovery after an abort. The abort has to land in the middle of a conversion, and the new request must then fall between the two recovery ticks. The bench handles this by stepping the enable one tick at a time. It aborts a full-scale input after exactly three resolved bits, then requests a new start before the next tick. It then checks that the hold switch stays closed for one tick, opens on the second, and that the held conversion still yields the right code.

// File: rtl/sar_seq_pkg.sv
// Package: shared state type and acquisition length decode for the
// successive-approximation sequencer. Assumes lengths fit ACQ_CNT_W bits.
package sar_seq_pkg;

    localparam int ACQ_CNT_W = 5;

    typedef enum logic [1:0] {
        ST_TRACK,
        ST_ACQ,
        ST_CONV,
        ST_RECOV
    } seq_state_t;

    // Map the 3-bit acquisition select to a number of conversion periods.
    function automatic logic [ACQ_CNT_W-1:0] acq_tads(input logic [2:0] sel);
        logic [ACQ_CNT_W-1:0] n;
        case (sel)
            3'd0:    n = 5'd0;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd6;
            3'd4:    n = 5'd8;
            3'd5:    n = 5'd12;
            3'd6:    n = 5'd16;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
// Sequencer state machine. Owns the start/busy bit, acquisition and
// recovery counters and the conversion step count. All progress happens on
// cycles with tad_tick high; an abort takes effect in any cycle.
// Assumes RECOV_TADS >= 1 and fits the shared counter width.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int RECOV_TADS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tad_tick,
    input  logic       start_set,
    input  logic       start_clr,
    input  logic [2:0] acq_sel,
    input  logic       cont_en,
    output logic       busy,
    output logic       in_conv,
    output logic       conv_load,
    output logic       conv_step,
    output logic       conv_done,
    output logic       conv_abort
);

    localparam int STEP_W = $clog2(RES_W + 1);
    localparam logic [STEP_W-1:0]    LAST_STEP = STEP_W'(RES_W);
    localparam logic [ACQ_CNT_W-1:0] RECOV_N   = ACQ_CNT_W'(RECOV_TADS);
    localparam logic [ACQ_CNT_W-1:0] ONE       = ACQ_CNT_W'(1);

    seq_state_t           state;
    logic [ACQ_CNT_W-1:0] cnt;
    logic [STEP_W-1:0]    step;
    logic                 go;
    logic [ACQ_CNT_W-1:0] acq_len;
    logic                 recov_end;
    logic                 launch;

    // Decode the launch and conversion event strobes.
    always_comb begin
        acq_len    = acq_tads(acq_sel);
        recov_end  = (state == ST_RECOV) && (cnt == ONE);
        launch     = tad_tick && go && !start_clr &&
                     ((state == ST_TRACK) || recov_end);
        conv_load  = (launch && (acq_len == '0)) ||
                     ((state == ST_ACQ) && tad_tick && !start_clr && (cnt == ONE));
        conv_abort = (state == ST_CONV) && start_clr;
        conv_done  = (state == ST_CONV) && !start_clr && tad_tick && (step == LAST_STEP);
        conv_step  = (state == ST_CONV) && !start_clr && tad_tick && (step != LAST_STEP);
    end

    assign busy    = go;
    assign in_conv = (state == ST_CONV);

    // Start/busy bit: clear beats set, completion drops it unless continuous.
    always_ff @(posedge clk) begin
        if (!rst_n)                    go <= 1'b0;
        else if (start_clr)            go <= 1'b0;
        else if (start_set)            go <= 1'b1;
        else if (conv_done && !cont_en) go <= 1'b0;
    end

    // Phase sequencing with acquisition, step and recovery counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_TRACK;
            cnt   <= '0;
            step  <= '0;
        end else begin
            case (state)
                ST_TRACK, ST_RECOV: begin
                    if (launch) begin
                        step <= '0;
                        if (acq_len == '0) begin
                            state <= ST_CONV;
                        end else begin
                            state <= ST_ACQ;
                            cnt   <= acq_len;
                        end
                    end else if ((state == ST_RECOV) && tad_tick) begin
                        if (cnt == ONE) state <= ST_TRACK;
                        else            cnt   <= cnt - ONE;
                    end
                end
                ST_ACQ: begin
                    if (start_clr) begin
                        state <= ST_TRACK;
                    end else if (tad_tick) begin
                        if (cnt == ONE) begin
                            state <= ST_CONV;
                            step  <= '0;
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                end
                default: begin
                    if (conv_abort || conv_done) begin
                        state <= ST_RECOV;
                        cnt   <= RECOV_N;
                    end else if (conv_step) begin
                        step <= step + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_conv |-> (step <= LAST_STEP));

    assert_abort_clears_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !busy);

    assert_recov_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done || conv_abort) |=> ((state == ST_RECOV) && (cnt == RECOV_N)));

    assert_no_early_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RECOV) && (cnt != ONE)) |=> !in_conv);

endmodule

// File: rtl/sar_seq_sar.sv
// Successive-approximation register: keeps the resolved bits and the current
// trial mask, and forms the DAC trial code. Assumes conv_step is only
// asserted while in_conv is high.
module sar_seq_sar #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_conv,
    input  logic             conv_load,
    input  logic             conv_step,
    input  logic             cmp_below,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] partial
);

    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] resolved;
    logic [RES_W-1:0] mask;

    // Load the MSB trial at start; decide one bit per step, shift the trial down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resolved <= '0;
            mask     <= '0;
        end else if (conv_load) begin
            resolved <= '0;
            mask     <= MSB_MASK;
        end else if (conv_step) begin
            if (!cmp_below) resolved <= resolved | mask;
            mask <= mask >> 1;
        end
    end

    // Trial code is visible only during conversion.
    always_comb begin
        dac_code = in_conv ? (resolved | mask) : '0;
        partial  = resolved;
    end

    assert_trial_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_load |=> (dac_code == MSB_MASK));

    assert_resolved_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_step |=> (($past(partial) & ~partial) == '0));

endmodule

// File: rtl/sar_seq.sv
// Top of the conversion sequencer: joins the state machine and the
// approximation register and holds the result register and the sticky done
// flag. The analog comparator, DAC and hold capacitor sit outside.
module sar_seq #(
    parameter int RES_W      = 10,
    parameter int RECOV_TADS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tad_tick,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic [2:0]       acq_sel,
    input  logic             cont_en,
    input  logic             flag_clr,
    input  logic             cmp_below,
    output logic             busy,
    output logic             sample_on,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done_flag
);

    logic             in_conv;
    logic             conv_load;
    logic             conv_step;
    logic             conv_done;
    logic             conv_abort;
    logic [RES_W-1:0] partial_code;

    sar_seq_ctrl #(.RES_W(RES_W), .RECOV_TADS(RECOV_TADS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tad_tick   (tad_tick),
        .start_set  (start_set),
        .start_clr  (start_clr),
        .acq_sel    (acq_sel),
        .cont_en    (cont_en),
        .busy       (busy),
        .in_conv    (in_conv),
        .conv_load  (conv_load),
        .conv_step  (conv_step),
        .conv_done  (conv_done),
        .conv_abort (conv_abort)
    );

    sar_seq_sar #(.RES_W(RES_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_conv   (in_conv),
        .conv_load (conv_load),
        .conv_step (conv_step),
        .cmp_below (cmp_below),
        .dac_code  (dac_code),
        .partial   (partial_code)
    );

    assign sample_on = !in_conv;

    // Result register: loaded on completion or with the partial code on abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                       result <= '0;
        else if (conv_done || conv_abort) result <= partial_code;
    end

    // Sticky done flag: completion wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_flag <= 1'b0;
        else if (conv_done) done_flag <= 1'b1;
        else if (flag_clr)  done_flag <= 1'b0;
    end

    assert_result_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (done_flag && (result == $past(partial_code))));

    assert_abort_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_abort && !flag_clr) |=> (done_flag == $past(done_flag)));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

endmodule

// File: tb/sar_seq_bench.sv
// Directed bench: one task per scenario; ideal comparator against vin.
module sar_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tad_tick = 1'b0;
    logic       start_set = 1'b0;
    logic       start_clr = 1'b0;
    logic [2:0] acq_sel = 3'd0;
    logic       cont_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cmp_below;
    logic       busy, sample_on, done_flag;
    logic [9:0] dac_code, result;
    logic [9:0] vin = 10'd0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign cmp_below = (vin < dac_code);

    sar_seq u_sar_seq (
        .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .start_set(start_set),
        .start_clr(start_clr), .acq_sel(acq_sel), .cont_en(cont_en),
        .flag_clr(flag_clr), .cmp_below(cmp_below), .busy(busy),
        .sample_on(sample_on), .dac_code(dac_code), .result(result),
        .done_flag(done_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tad();
        @(negedge clk) tad_tick = 1'b1;
        @(negedge clk) tad_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_set();
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) start_clr = 1'b1;
        @(negedge clk) start_clr = 1'b0;
    endtask

    task automatic pulse_flag_clr();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    // Ticks until sample_on returns high, counting the one already spent.
    task automatic count_conv(output int n);
        n = 1;
        while (sample_on == 1'b0 && n < 40) begin tad(); n++; end
        n--;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done_flag", done_flag, 0);
        check("R1 result", result, 0);
        check("R1 dac_code", dac_code, 0);
        check("R1 sample_on", sample_on, 1);
    endtask

    task automatic t_basic(input logic [9:0] v, input bit probe);
        int n;
        vin = v; acq_sel = 3'd0;
        pulse_set();
        check("R11 dac idle", dac_code, 0);
        tad();
        check("R2 conv starts on first tick", sample_on, 0);
        check("R4 msb trial", dac_code, 10'h200);
        if (probe) begin
            tad();
            check("R4 second trial", dac_code, (v >= 10'h200) ? 10'h300 : 10'h100);
            n = 2;
            while (sample_on == 1'b0 && n < 40) begin tad(); n++; end
            n--;
        end else begin
            tad();
            n = 2;
            while (sample_on == 1'b0 && n < 40) begin tad(); n++; end
            n--;
        end
        check("R3 conv length", n, 11);
        check("R5 result", result, v);
        check("R5 flag", done_flag, 1);
        check("R5 busy clear", busy, 0);
        check("R11 dac after", dac_code, 0);
        tad(); tad();
    endtask

    task automatic t_acq(input logic [2:0] sel, input int len);
        int n;
        acq_sel = sel; vin = 10'h0AA;
        pulse_set();
        n = 0;
        while (sample_on == 1'b1 && n < 40) begin tad(); n++; end
        check("R2 acquisition ticks", n, len + 1);
        count_conv(n);
        check("R3 conv length after acq", n, 11);
        check("R5 result after acq", result, 10'h0AA);
        tad(); tad();
        acq_sel = 3'd0;
    endtask

    task automatic t_flag();
        check("R6 flag still set", done_flag, 1);
        tad(); tad();
        check("R6 flag sticky", done_flag, 1);
        pulse_flag_clr();
        check("R6 flag cleared", done_flag, 0);
    endtask

    task automatic t_abort_and_hold();
        int n;
        vin = 10'h3FF; acq_sel = 3'd0;
        pulse_set();
        tad(); tad(); tad(); tad();
        check("R4 trial after three steps", dac_code, 10'h3C0);
        pulse_clr();
        check("R7 partial result", result, 10'h380);
        check("R7 flag unchanged", done_flag, 0);
        check("R7 busy clear", busy, 0);
        check("R7 tracking again", sample_on, 1);
        pulse_set();
        tad();
        check("R8 still recovering", sample_on, 1);
        tad();
        check("R8 held start runs", sample_on, 0);
        count_conv(n);
        check("R8 held conv length", n, 11);
        check("R8 held conv result", result, 10'h3FF);
        check("R5 flag after held conv", done_flag, 1);
        tad(); tad();
        pulse_flag_clr();
    endtask

    task automatic t_cont();
        int n;
        vin = 10'h155; acq_sel = 3'd0; cont_en = 1'b1;
        pulse_set();
        tad();
        count_conv(n);
        check("R9 first result", result, 10'h155);
        check("R9 busy kept", busy, 1);
        check("R9 flag", done_flag, 1);
        vin = 10'h0F0;
        tad();
        check("R9 recovery tick", sample_on, 1);
        tad();
        check("R9 auto restart", sample_on, 0);
        count_conv(n);
        check("R9 second length", n, 11);
        check("R9 second result", result, 10'h0F0);
        cont_en = 1'b0;
        pulse_clr();
        tad(); tad(); tad();
        check("R9 stopped", sample_on, 1);
        check("R9 busy off", busy, 0);
        pulse_flag_clr();
    endtask

    task automatic t_acq_abort();
        acq_sel = 3'd7; vin = 10'h011;
        pulse_set();
        tad(); tad(); tad();
        pulse_clr();
        check("R10 busy clear", busy, 0);
        check("R10 result unchanged", result, 10'h0F0);
        tad(); tad(); tad();
        check("R10 no conversion", sample_on, 1);
        check("R10 flag unchanged", done_flag, 0);
        acq_sel = 3'd0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic(10'h2A5, 1'b1);
        t_flag();
        t_basic(10'h000, 1'b0);
        t_basic(10'h3FF, 1'b0);
        t_basic(10'h200, 1'b1);
        pulse_flag_clr();
        t_acq(3'd0, 0);
        t_acq(3'd1, 2);
        t_acq(3'd2, 4);
        t_acq(3'd5, 12);
        t_acq(3'd7, 20);
        pulse_flag_clr();
        t_abort_and_hold();
        t_cont();
        t_acq_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule